// File: doc/BRIEF.md
# Dual Threshold Alarm Monitor

This block watches two independently configured alarm channels over a common set of sampled measurement streams: supply voltage, angular rate, an auxiliary converter input and temperature. Each stream arrives in a raw and a filtered form, and one strobe marks every cycle that carries a new sample. A shared control word assigns a stream to each channel, chooses static-level or rate-of-change operation per channel, and picks raw or filtered data for both. Each channel has a 16-bit magnitude word that carries a threshold and a comparison direction, and an 8-bit sample count.

In static-level mode, each new sample is compared with the threshold. In rate-of-change mode, the channel forms the difference between each sample and the previous one, sums these differences over N samples and compares their truncated average with the threshold. A hit sets a sticky status bit for that channel. The bit stays set until a clear pulse arrives. The two status bits can drive one of two alarm lines, with a selectable polarity.

Each channel runs a four-state machine. CH_OFF is the idle or restart state. CH_LEVEL runs static comparison. CH_PRIME waits for the first sample of a rate run, which only becomes the reference. CH_ACCUM sums the differences. The transitions are:

- CH_OFF to CH_LEVEL or CH_PRIME (enter) when the selected source code is active. The mode bit picks the target.
- CH_PRIME to CH_ACCUM (prime) on the first valid sample.
- Any running state back to CH_OFF (restart) when the source becomes inactive, or when the mode, source code or filter choice changes.
- All other cases hold the current state.

The latched status bits are not touched by a restart.

Top module: `alarm_pair_top`

## Requirements
- R1: Control bits 10:8 select the stream for channel 1 and bits 14:12 for channel 2, using these codes: 001 = supply, 010 = rate, 101 = auxiliary, 110 = temperature. Control bit 4 set means both channels use the filtered stream; bit 4 clear means both use the raw stream.
- R2: In static mode (channel 1 mode bit 11 = 0, channel 2 mode bit 15 = 0), every valid sample is compared strictly with threshold bits 13:0 of the magnitude word. Magnitude bit 15 = 1 means "greater than" and 0 means "less than". A hit sets the status bit at the clock edge that takes the sample.
- R3: Rate and temperature samples and their thresholds are 14-bit two's complement and are compared signed. Supply and auxiliary values are straight binary and are compared unsigned.
- R4: In rate mode (mode bit = 1), the first sample after entering only sets the reference. Each later sample adds (sample minus previous sample) to a sum. Every N-th difference, the sum divided by N, truncated toward zero, is compared with the threshold, and the sum restarts.
- R5: A sample count of 0 behaves as a count of 1, so every difference is evaluated.
- R6: Status bits stay set until a clear pulse. A clear and a new hit in the same cycle leave the bit set. Both bits are 0 after reset.
- R7: Source code 000 and the codes 011, 100 and 111 never set the channel's status.
- R8: Control bit 2 enables the alarm output, bit 0 picks the line (1 = line 1, 0 = line 0) and bit 1 gives the polarity (1 = active high). The unselected line, and both lines while bit 2 is clear, are driven 0.
- R9: The selected line is in its asserted level while either channel has its status set and an active source code; otherwise it is in its deasserted level.
- R10: The two channels are independent. A hit on one channel never changes the other channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | New sample on all streams this cycle |
| sup_raw | input | 14 | Supply sample, unfiltered |
| sup_flt | input | 14 | Supply sample, filtered |
| gyr_raw | input | 14 | Rate sample, unfiltered |
| gyr_flt | input | 14 | Rate sample, filtered |
| aux_raw | input | 14 | Auxiliary sample, unfiltered |
| aux_flt | input | 14 | Auxiliary sample, filtered |
| tmp_raw | input | 14 | Temperature sample, unfiltered |
| tmp_flt | input | 14 | Temperature sample, filtered |
| alm_ctrl | input | 16 | Shared alarm control word |
| alm1_mag | input | 16 | Channel 1 direction and threshold |
| alm2_mag | input | 16 | Channel 2 direction and threshold |
| alm1_cnt | input | 8 | Channel 1 averaging count |
| alm2_cnt | input | 8 | Channel 2 averaging count |
| sts_clr | input | 1 | Clears both status bits |
| alm1_sts | output | 1 | Channel 1 latched status |
| alm2_sts | output | 1 | Channel 2 latched status |
| alm_line | output | 2 | Alarm output lines |

## Verification
Static comparisons are tried with values just at, above and below the threshold, which shows that the comparison is strict. They are also tried with values whose top bit is set, which shows whether a signed or an unsigned comparison is made for each kind of source. Raw and filtered streams are given different values, so the wrong stream choice shows up as a missed or a false hit.

Rate runs use ramps whose difference sum is not a multiple of N, in both directions. This shows that the result is truncated toward zero rather than floored, and that the check fires only on the N-th difference. A zero count exposes a missing one-sample fallback.

Line tests walk the enable, select and polarity bits with the status set and with it clear. A source code switched to disabled while the status is set shows that only active channels drive the line.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'b000,
        SRC_SUP  = 3'b001,
        SRC_GYR  = 3'b010,
        SRC_AUX  = 3'b101,
        SRC_TMP  = 3'b110
    } src_code_t;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_LEVEL = 2'd1,
        CH_PRIME = 2'd2,
        CH_ACCUM = 2'd3
    } ch_state_t;

    localparam int NUM_SRC = 4;

endpackage

// File: rtl/alarm_src_sel.sv
module alarm_src_sel
    import alarm_pkg::*;
#(
    parameter int DW = 14
) (
    input  logic [2:0]                  code,
    input  logic                        use_flt,
    input  logic [NUM_SRC-1:0][DW-1:0]  raw_bus,
    input  logic [NUM_SRC-1:0][DW-1:0]  flt_bus,
    output logic [DW-1:0]               sample,
    output logic                        is_signed,
    output logic                        active
);

    logic [NUM_SRC-1:0][DW-1:0] pick;

    // filtered/raw choice per stream
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
        assign pick[g] = use_flt ? flt_bus[g] : raw_bus[g];
    end

    always_comb begin
        sample    = '0;
        is_signed = 1'b0;
        active    = 1'b1;
        case (code)
            SRC_SUP: sample = pick[0];
            SRC_GYR: begin sample = pick[1]; is_signed = 1'b1; end
            SRC_AUX: sample = pick[2];
            SRC_TMP: begin sample = pick[3]; is_signed = 1'b1; end
            default: active = 1'b0;
        endcase
    end

endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
    import alarm_pkg::*;
#(
    parameter int DW = 14,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic          mode_rate,
    input  logic [2:0]    code,
    input  logic          use_flt,
    input  logic          active,
    input  logic          is_signed,
    input  logic [DW-1:0] sample,
    input  logic          dir_gt,
    input  logic [DW-1:0] thr,
    input  logic [CW-1:0] n_cfg,
    input  logic          clr,
    output logic          sts
);

    localparam int SW   = DW + 2 + CW;
    localparam int CFGW = 5;

    ch_state_t state_q, state_d;
    logic [CFGW-1:0]      cfg_q, cfg_now;
    logic signed [SW-1:0] prev_q, sum_q;
    logic [CW-1:0]        cnt_q;

    logic signed [SW-1:0] x_w, thr_w, delta, sum_nx, avg;
    logic [CW-1:0]        n_eff;
    logic                 run_ok, last, trip;

    function automatic logic signed [SW-1:0] widen(input logic [DW-1:0] v,
                                                   input logic sg);
        return sg ? {{(SW-DW){v[DW-1]}}, v} : {{(SW-DW){1'b0}}, v};
    endfunction

    function automatic logic hit(input logic signed [SW-1:0] a,
                                 input logic signed [SW-1:0] b,
                                 input logic gt);
        return gt ? (a > b) : (a < b);
    endfunction

    assign cfg_now = {mode_rate, code, use_flt};
    assign x_w     = widen(sample, is_signed);
    assign thr_w   = widen(thr, is_signed);
    assign delta   = x_w - prev_q;
    assign sum_nx  = sum_q + delta;
    assign n_eff   = (n_cfg == '0) ? CW'(1) : n_cfg;
    assign avg     = sum_nx / $signed({{(SW-CW){1'b0}}, n_eff});
    assign last    = (cnt_q == n_eff - CW'(1));
    assign run_ok  = (state_q != CH_OFF) && active && (cfg_now == cfg_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (active) state_d = mode_rate ? CH_PRIME : CH_LEVEL;
            end
            CH_LEVEL: begin
                if (!run_ok) state_d = CH_OFF;
            end
            CH_PRIME: begin
                if (!run_ok)  state_d = CH_OFF;
                else if (vld) state_d = CH_ACCUM;
            end
            CH_ACCUM: begin
                if (!run_ok) state_d = CH_OFF;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // averaging datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            prev_q <= '0;
            sum_q  <= '0;
            cnt_q  <= '0;
        end else if (state_q == CH_OFF) begin
            cfg_q <= cfg_now;
            sum_q <= '0;
            cnt_q <= '0;
        end else if (run_ok && vld) begin
            prev_q <= x_w;
            if (state_q == CH_ACCUM && !last) begin
                sum_q <= sum_nx;
                cnt_q <= cnt_q + CW'(1);
            end else begin
                sum_q <= '0;
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        trip = 1'b0;
        if (run_ok && vld) begin
            unique case (state_q)
                CH_LEVEL: trip = hit(x_w, thr_w, dir_gt);
                CH_ACCUM: trip = last && hit(avg, thr_w, dir_gt);
                CH_PRIME,
                CH_OFF:   trip = 1'b0;
            endcase
        end
    end

    // output process: sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sts <= 1'b0;
        else if (trip) sts <= 1'b1;
        else if (clr)  sts <= 1'b0;
    end

endmodule

// File: rtl/alarm_line_drv.sv
module alarm_line_drv #(
    parameter int NLINE = 2
) (
    input  logic             en,
    input  logic             pol_hi,
    input  logic             sel,
    input  logic             act1,
    input  logic             act2,
    input  logic             sts1,
    input  logic             sts2,
    output logic [NLINE-1:0] line
);

    logic asserted;
    assign asserted = (sts1 && act1) || (sts2 && act2);

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        assign line[g] = en && (sel == g[0]) && (pol_hi ? asserted : !asserted);
    end

endmodule

// File: rtl/alarm_pair_top.sv
module alarm_pair_top
    import alarm_pkg::*;
#(
    parameter int DW = 14,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] sup_raw,
    input  logic [DW-1:0] sup_flt,
    input  logic [DW-1:0] gyr_raw,
    input  logic [DW-1:0] gyr_flt,
    input  logic [DW-1:0] aux_raw,
    input  logic [DW-1:0] aux_flt,
    input  logic [DW-1:0] tmp_raw,
    input  logic [DW-1:0] tmp_flt,
    input  logic [15:0]   alm_ctrl,
    input  logic [15:0]   alm1_mag,
    input  logic [15:0]   alm2_mag,
    input  logic [CW-1:0] alm1_cnt,
    input  logic [CW-1:0] alm2_cnt,
    input  logic          sts_clr,
    output logic          alm1_sts,
    output logic          alm2_sts,
    output logic [1:0]    alm_line
);

    localparam int NCH = 2;

    logic [NUM_SRC-1:0][DW-1:0] raw_bus, flt_bus;
    logic [NCH-1:0][2:0]        code;
    logic [NCH-1:0]             mode_rate, act, sgn, sts;
    logic [NCH-1:0][DW-1:0]     smp;
    logic [NCH-1:0][15:0]       mag;
    logic [NCH-1:0][CW-1:0]     cnt;
    logic                       unused_bits;

    assign raw_bus = {tmp_raw, aux_raw, gyr_raw, sup_raw};
    assign flt_bus = {tmp_flt, aux_flt, gyr_flt, sup_flt};

    assign code[0]      = alm_ctrl[10:8];
    assign code[1]      = alm_ctrl[14:12];
    assign mode_rate[0] = alm_ctrl[11];
    assign mode_rate[1] = alm_ctrl[15];
    assign mag[0]       = alm1_mag;
    assign mag[1]       = alm2_mag;
    assign cnt[0]       = alm1_cnt;
    assign cnt[1]       = alm2_cnt;
    assign unused_bits  = ^{alm_ctrl[7:5], alm_ctrl[3], alm1_mag[14:DW], alm2_mag[14:DW]};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        alarm_src_sel #(.DW(DW)) u_sel (
            .code     (code[c]),
            .use_flt  (alm_ctrl[4]),
            .raw_bus  (raw_bus),
            .flt_bus  (flt_bus),
            .sample   (smp[c]),
            .is_signed(sgn[c]),
            .active   (act[c])
        );

        alarm_channel #(.DW(DW), .CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .vld      (smp_vld),
            .mode_rate(mode_rate[c]),
            .code     (code[c]),
            .use_flt  (alm_ctrl[4]),
            .active   (act[c]),
            .is_signed(sgn[c]),
            .sample   (smp[c]),
            .dir_gt   (mag[c][15]),
            .thr      (mag[c][DW-1:0]),
            .n_cfg    (cnt[c]),
            .clr      (sts_clr),
            .sts      (sts[c])
        );
    end

    alarm_line_drv #(.NLINE(2)) u_line (
        .en    (alm_ctrl[2]),
        .pol_hi(alm_ctrl[1]),
        .sel   (alm_ctrl[0]),
        .act1  (act[0]),
        .act2  (act[1]),
        .sts1  (sts[0]),
        .sts2  (sts[1]),
        .line  (alm_line)
    );

    assign alm1_sts = sts[0];
    assign alm2_sts = sts[1];

endmodule

// File: rtl/alarm_pair_chk.sv
module alarm_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        smp_vld,
    input logic [15:0] alm_ctrl,
    input logic        sts_clr,
    input logic        alm1_sts,
    input logic        alm2_sts,
    input logic [1:0]  alm_line
);

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_ctrl[10:8] == 3'b000 && !alm1_sts) |=> !alm1_sts); // R7

    AST_NEED_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !alm1_sts && !alm2_sts) |=> (!alm1_sts && !alm2_sts)); // R2

    AST_STICKY_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        (alm1_sts && !sts_clr) |=> alm1_sts); // R6

    AST_STICKY_CH2: assert property (@(posedge clk) disable iff (!rst_n)
        (alm2_sts && !sts_clr) |=> alm2_sts); // R6

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !smp_vld) |=> (!alm1_sts && !alm2_sts)); // R6

    AST_LINE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !alm_ctrl[2] |-> (alm_line == 2'b00)); // R8

    AST_LINE_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_ctrl[2] && alm_ctrl[0]) |-> !alm_line[0]); // R8

    AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alm_line)); // R8

    AST_LINE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_ctrl[2] && alm_ctrl[1] && !alm_ctrl[0] && alm1_sts
         && alm_ctrl[10:8] == 3'b010) |-> alm_line[0]); // R9

endmodule

bind alarm_pair_top alarm_pair_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .alm_ctrl(alm_ctrl),
    .sts_clr (sts_clr),
    .alm1_sts(alm1_sts),
    .alm2_sts(alm2_sts),
    .alm_line(alm_line)
);

// File: tb/alarm_pair_top_test.sv
`timescale 1ns/1ps
module alarm_pair_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [13:0] sup_raw = '0, sup_flt = '0, gyr_raw = '0, gyr_flt = '0;
    logic [13:0] aux_raw = '0, aux_flt = '0, tmp_raw = '0, tmp_flt = '0;
    logic [15:0] alm_ctrl = '0, alm1_mag = '0, alm2_mag = '0;
    logic [7:0]  alm1_cnt = '0, alm2_cnt = '0;
    logic        sts_clr = 1'b0;
    logic        alm1_sts, alm2_sts;
    logic [1:0]  alm_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alarm_pair_top uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .sup_raw(sup_raw), .sup_flt(sup_flt), .gyr_raw(gyr_raw), .gyr_flt(gyr_flt),
        .aux_raw(aux_raw), .aux_flt(aux_flt), .tmp_raw(tmp_raw), .tmp_flt(tmp_flt),
        .alm_ctrl(alm_ctrl), .alm1_mag(alm1_mag), .alm2_mag(alm2_mag),
        .alm1_cnt(alm1_cnt), .alm2_cnt(alm2_cnt), .sts_clr(sts_clr),
        .alm1_sts(alm1_sts), .alm2_sts(alm2_sts), .alm_line(alm_line)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [15:0] c, input logic [15:0] m1,
                           input logic [15:0] m2, input logic [7:0] n1,
                           input logic [7:0] n2);
        @(negedge clk);
        alm_ctrl = c; alm1_mag = m1; alm2_mag = m2; alm1_cnt = n1; alm2_cnt = n2;
        repeat (3) @(negedge clk);
    endtask

    task automatic smp();
        @(negedge clk); smp_vld = 1'b1;
        @(negedge clk); smp_vld = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); sts_clr = 1'b1;
        @(negedge clk); sts_clr = 1'b0;
    endtask

    task automatic gyr(input int v);
        gyr_raw = 14'(v); smp();
    endtask

    task automatic t_reset();
        chk("R6 reset ch1", alm1_sts, 0);
        chk("R6 reset ch2", alm2_sts, 0);
        chk("R8 reset line", alm_line, 0);
    endtask

    task automatic t_static_rate_src();
        set_cfg(16'h0200, 16'h8064, 16'h0000, 8'd1, 8'd1);
        gyr_raw = 14'h3FFB; gyr_flt = 0; smp();
        chk("R3 signed -5 not > 100", alm1_sts, 0);
        gyr_raw = 50; gyr_flt = 200; smp();
        chk("R1 raw chosen, filtered ignored", alm1_sts, 0);
        gyr_raw = 100; smp();
        chk("R2 strict at threshold", alm1_sts, 0);
        gyr_raw = 101; smp();
        chk("R2 above threshold trips", alm1_sts, 1);
        gyr_raw = 0; smp();
        chk("R6 status latched", alm1_sts, 1);
        clr();
        chk("R6 cleared", alm1_sts, 0);
        set_cfg(16'h0210, 16'h8064, 16'h0000, 8'd1, 8'd1);
        gyr_raw = 500; gyr_flt = 50; smp();
        chk("R1 filtered chosen, raw ignored", alm1_sts, 0);
        gyr_flt = 150; smp();
        chk("R1 filtered trips", alm1_sts, 1);
        gyr_flt = 0;
        clr();
    endtask

    task automatic t_unsigned_and_temp();
        set_cfg(16'h1000, 16'h8000, 16'h03E8, 8'd1, 8'd1);
        sup_raw = 14'h3FFB; gyr_raw = 5000; smp();
        chk("R3 unsigned 16379 not < 1000", alm2_sts, 0);
        chk("R7 disabled code on ch1", alm1_sts, 0);
        sup_raw = 999; smp();
        chk("R2 less-than trips", alm2_sts, 1);
        chk("R10 ch1 untouched", alm1_sts, 0);
        clr();
        set_cfg(16'h6000, 16'h8000, 16'hBFEC, 8'd1, 8'd1);
        tmp_raw = 14'h3FE2; smp();
        chk("R3 temp -30 not > -20", alm2_sts, 0);
        tmp_raw = 14'h3FF6; smp();
        chk("R3 temp -10 > -20", alm2_sts, 1);
        clr();
        set_cfg(16'h0300, 16'h8000, 16'h0000, 8'd1, 8'd1);
        gyr_raw = 5000; smp();
        chk("R7 inactive code 011", alm1_sts, 0);
    endtask

    task automatic t_rate_mode();
        set_cfg(16'h0A00, 16'h800A, 16'h0000, 8'd4, 8'd1);
        clr();
        gyr(0); gyr(20); gyr(40); gyr(60);
        chk("R4 no decision before N-th delta", alm1_sts, 0);
        gyr(80);
        chk("R4 avg 20 > 10", alm1_sts, 1);
        clr();
        gyr(90); gyr(100); gyr(110); gyr(123);
        chk("R4 avg 43/4 truncates to 10", alm1_sts, 0);
        @(negedge clk); alm1_mag = 16'h3FF6;
        gyr(113); gyr(103); gyr(93); gyr(80);
        chk("R4 avg -43/4 truncates toward zero", alm1_sts, 0);
        gyr(60); gyr(40); gyr(20); gyr(0);
        chk("R4 avg -20 < -10", alm1_sts, 1);
        clr();
    endtask

    task automatic t_zero_count();
        set_cfg(16'hD000, 16'h0000, 16'h8005, 8'd1, 8'd0);
        clr();
        aux_raw = 100; smp();
        chk("R4 first sample only primes", alm2_sts, 0);
        aux_raw = 103; smp();
        chk("R5 delta 3 not > 5", alm2_sts, 0);
        aux_raw = 110; smp();
        chk("R5 single delta 7 trips", alm2_sts, 1);
        clr();
    endtask

    task automatic t_line();
        set_cfg(16'h0206, 16'h8064, 16'h03E8, 8'd1, 8'd1);
        chk("R8 active-high idle", alm_line, 0);
        gyr_raw = 200; smp();
        chk("R9 line 0 asserted", alm_line, 1);
        set_cfg(16'h0207, 16'h8064, 16'h03E8, 8'd1, 8'd1);
        chk("R8 select line 1", alm_line, 2);
        set_cfg(16'h0205, 16'h8064, 16'h03E8, 8'd1, 8'd1);
        chk("R8 active-low asserted", alm_line, 0);
        clr();
        chk("R8 active-low idle", alm_line, 2);
        set_cfg(16'h0201, 16'h8064, 16'h03E8, 8'd1, 8'd1);
        chk("R8 output disabled", alm_line, 0);
        set_cfg(16'h1006, 16'h8064, 16'h03E8, 8'd1, 8'd1);
        sup_raw = 10; smp();
        chk("R9 ch2 alone drives line", alm_line, 1);
        set_cfg(16'h0006, 16'h8064, 16'h03E8, 8'd1, 8'd1);
        chk("R9 inactive channel ignored", alm_line, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_static_rate_src();
        t_unsigned_and_temp();
        t_rate_mode();
        t_zero_count();
        t_line();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule